// File: doc/BRIEF.md
# Register Rename Stage with Move Elimination

This block is the rename stage of a small out-of-order core. It holds the table that says which physical register currently backs each architectural register. Every cycle it can take a group of up to four micro-ops, each with a class, a source register and a destination register. For each one it returns the physical source tag, the physical destination tag, the tag the destination used to map to, and two flags: whether the micro-op is already complete and whether it still needs an execution unit.

Register-to-register copies between different registers are resolved inside the table with zero latency. The destination is pointed at the physical register the source already uses, and no execution unit is needed. A count per physical register records how many mappings share it. A physical register goes back to the free pool only when its count drops to zero. The count drops through a release port that the commit side drives with old tags, once the micro-ops that overwrote them retire.

A small state machine tracks what the output register holds:
- `ST_IDLE`: no group was offered in the last cycle.
- `ST_EMIT`: a group was renamed and the outputs are valid.
- `ST_HOLD`: a group was offered but stalled for lack of free registers.

The transitions are the same from every state: accept goes to `ST_EMIT`, offered but stalled goes to `ST_HOLD`, and nothing offered goes to `ST_IDLE`.

Top module: `rr_rename_top`

## Requirements
- R1: After reset, architectural register r maps to physical register r, and physical registers 16 to 47 are free. `out_vld` is 0 and `in_ready` is 1. Fresh registers are handed out lowest number first, in slot order.
- R2: A move (class 1) whose source and destination differ, and whose source register count is below 7, is eliminated. Its destination tag equals its source tag, done is 1 and exe is 0.
- R3: A move whose source and destination are the same register is never eliminated. It gets a fresh destination tag, with exe 1 and done 0.
- R4: A NOP (class 2) has done 1 and exe 0 and leaves the map unchanged. A zeroing idiom (class 3) gets a fresh destination tag with done 1 and exe 0.
- R5: An 8-bit zero-extension (class 4) is eliminated under the same rules as a move. A 16-bit zero-extension (class 5) always gets a fresh tag and executes. Plain ALU operations are class 0.
- R6: Each source tag reflects the latest mapping of its register, including mappings made by earlier slots of the same group.
- R7: A fresh destination tag is never a register that any mapping or any unreleased old tag still references. Fresh tags within a group are distinct.
- R8: When the source register's count, including eliminations earlier in the same group, has reached 7, an eligible move executes with a fresh tag instead.
- R9: If the free pool cannot supply a register for every non-eliminated writing slot, `in_ready` is 0. Nothing is renamed that cycle and `out_vld` is 0 in the next cycle.
- R10: `out_old` is the tag the destination mapped to before the micro-op. Each release of a tag lowers its count by one, and a register whose count reaches zero returns to the free pool.
- R11: An accepted group appears on the outputs in the next cycle with `out_vld` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| in_valid | input | 1 | a group is offered |
| in_slot | input | 4 | per-slot valid |
| in_kind | input | 12 | 3-bit class per slot |
| in_src | input | 16 | 4-bit source register per slot |
| in_dst | input | 16 | 4-bit destination register per slot |
| in_ready | output | 1 | the offered group can be renamed this cycle |
| rel_vld | input | 4 | release strobes |
| rel_tag | input | 24 | 6-bit tags to release |
| out_vld | output | 1 | renamed group valid |
| out_slot | output | 4 | per-slot valid of renamed group |
| out_ps | output | 24 | physical source tags |
| out_pd | output | 24 | physical destination tags |
| out_old | output | 24 | previous destination tags |
| out_done | output | 4 | already complete |
| out_exe | output | 4 | needs an execution unit |

## Verification
Two functions can fall in the same cycle:
- A release that brings a register's count to zero, together with a group whose moves raise counts or whose writers draw fresh registers.
- An elimination decision that depends on increments made by earlier slots of the same group.

The bench provokes the first by driving random releases alongside random groups. It provokes the second with directed groups that copy one register many times. A reference model holds its own map and counts, and judges every source tag, every elimination decision, the freshness of every drawn register and the ready signal against them.

// File: rtl/rr_pkg.sv
`timescale 1ns/1ps
package rr_pkg;
    typedef enum logic [2:0] {
        K_ALU  = 3'd0,
        K_MOV  = 3'd1,
        K_NOP  = 3'd2,
        K_ZERO = 3'd3,
        K_ZX8  = 3'd4,
        K_ZX16 = 3'd5
    } kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EMIT = 2'd1,
        ST_HOLD = 2'd2
    } rr_state_e;
endpackage

// File: rtl/rr_free_pool.sv
`timescale 1ns/1ps
module rr_free_pool #(
    parameter int NARCH = 16,
    parameter int NPHYS = 48,
    parameter int W     = 4,
    localparam int PW   = $clog2(NPHYS),
    localparam int FW   = $clog2(NPHYS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [W-1:0]         take_v,
    input  logic [W-1:0][PW-1:0] take_t,
    input  logic [NPHYS-1:0]     give_i,
    output logic [W-1:0][PW-1:0] pick_o,
    output logic [FW-1:0]        avail_o
);
    logic [NPHYS-1:0] free_q;
    logic [NPHYS-1:0] taken;

    // lowest free first, one per slot
    always_comb begin
        logic [NPHYS-1:0] m;
        m = free_q;
        for (int k = 0; k < W; k++) begin
            pick_o[k] = '0;
            for (int j = NPHYS - 1; j >= 0; j--) begin
                if (m[j]) pick_o[k] = PW'(j);
            end
            m[pick_o[k]] = 1'b0;
        end
    end

    always_comb begin
        taken = '0;
        for (int i = 0; i < W; i++) begin
            if (take_v[i]) taken[take_t[i]] = 1'b1;
        end
    end

    assign avail_o = FW'($countones(free_q));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) free_q <= {{(NPHYS-NARCH){1'b1}}, {NARCH{1'b0}}};
        else        free_q <= (free_q & ~taken) | give_i;
    end
endmodule

// File: rtl/rr_ref_table.sv
`timescale 1ns/1ps
module rr_ref_table #(
    parameter int NARCH = 16,
    parameter int NPHYS = 48,
    parameter int CW    = 3,
    parameter int W     = 4,
    localparam int PW   = $clog2(NPHYS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [W-1:0]          set_v,
    input  logic [W-1:0][PW-1:0]  set_t,
    input  logic [W-1:0]          inc_v,
    input  logic [W-1:0][PW-1:0]  inc_t,
    input  logic [W-1:0]          dec_v,
    input  logic [W-1:0][PW-1:0]  dec_t,
    output logic [NPHYS-1:0][CW-1:0] cnt_o,
    output logic [NPHYS-1:0]      freed_o
);
    for (genvar j = 0; j < NPHYS; j++) begin : g_ent
        logic [CW-1:0] q;
        logic [CW:0]   nx;

        always_comb begin
            nx = {1'b0, q};
            for (int i = 0; i < W; i++) begin
                if (set_v[i] && set_t[i] == PW'(j)) nx = (CW+1)'(1);
            end
            for (int i = 0; i < W; i++) begin
                if (inc_v[i] && inc_t[i] == PW'(j)) nx = nx + (CW+1)'(1);
            end
            for (int i = 0; i < W; i++) begin
                if (dec_v[i] && dec_t[i] == PW'(j)) nx = nx - (CW+1)'(1);
            end
        end

        assign cnt_o[j]   = q;
        assign freed_o[j] = (q != '0) && (nx == '0);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= CW'((j < NARCH) ? 1 : 0);
            else        q <= nx[CW-1:0];
        end
    end
endmodule

// File: rtl/rr_group_decode.sv
`timescale 1ns/1ps
module rr_group_decode import rr_pkg::*; #(
    parameter int NARCH = 16,
    parameter int NPHYS = 48,
    parameter int CW    = 3,
    parameter int W     = 4,
    localparam int AW   = $clog2(NARCH),
    localparam int PW   = $clog2(NPHYS),
    localparam int NW   = $clog2(W + 1)
) (
    input  logic [NARCH-1:0][PW-1:0] map_i,
    input  logic [NPHYS-1:0][CW-1:0] cnt_i,
    input  logic [W-1:0][PW-1:0]     pick_i,
    input  logic [W-1:0]             slot_i,
    input  logic [W-1:0][2:0]        kind_i,
    input  logic [W-1:0][AW-1:0]     src_i,
    input  logic [W-1:0][AW-1:0]     dst_i,
    output logic [NARCH-1:0][PW-1:0] map_o,
    output logic [W-1:0][PW-1:0]     ps_o,
    output logic [W-1:0][PW-1:0]     pd_o,
    output logic [W-1:0][PW-1:0]     old_o,
    output logic [W-1:0]             done_o,
    output logic [W-1:0]             exe_o,
    output logic [W-1:0]             elim_o,
    output logic [W-1:0]             alloc_o,
    output logic [NW-1:0]            need_o
);
    localparam int SW = $clog2(W);
    localparam logic [CW:0] CMAX = {1'b0, {CW{1'b1}}};

    always_comb begin
        logic [NARCH-1:0][PW-1:0] m;
        logic [SW-1:0] kk;
        logic [CW:0]   cur;
        kind_e         kd;
        m      = map_i;
        kk     = '0;
        need_o = '0;
        for (int i = 0; i < W; i++) begin
            ps_o[i]    = m[src_i[i]];
            old_o[i]   = m[dst_i[i]];
            pd_o[i]    = old_o[i];
            done_o[i]  = 1'b0;
            exe_o[i]   = 1'b0;
            elim_o[i]  = 1'b0;
            alloc_o[i] = 1'b0;
            kd         = K_NOP;
            cur        = {1'b0, cnt_i[ps_o[i]]};
            for (int j = 0; j < i; j++) begin
                if (elim_o[j] && ps_o[j] == ps_o[i]) cur = cur + (CW+1)'(1);
            end
            if (slot_i[i]) begin
                kd = kind_e'(kind_i[i]);
                unique case (kd)
                    K_NOP: done_o[i] = 1'b1;
                    K_MOV, K_ZX8: begin
                        if (src_i[i] != dst_i[i] && cur < CMAX) begin
                            elim_o[i] = 1'b1;
                            done_o[i] = 1'b1;
                        end else begin
                            alloc_o[i] = 1'b1;
                            exe_o[i]   = 1'b1;
                        end
                    end
                    K_ZERO: begin
                        alloc_o[i] = 1'b1;
                        done_o[i]  = 1'b1;
                    end
                    default: begin
                        alloc_o[i] = 1'b1;
                        exe_o[i]   = 1'b1;
                    end
                endcase
            end
            if (elim_o[i]) pd_o[i] = ps_o[i];
            if (alloc_o[i]) begin
                pd_o[i] = pick_i[kk];
                kk      = kk + SW'(1);
                need_o  = need_o + NW'(1);
            end
            if (slot_i[i] && kd != K_NOP) m[dst_i[i]] = pd_o[i];
        end
        map_o = m;
    end
endmodule

// File: rtl/rr_rename_top.sv
`timescale 1ns/1ps
module rr_rename_top import rr_pkg::*; #(
    parameter int NARCH = 16,
    parameter int NPHYS = 48,
    parameter int CW    = 3,
    parameter int W     = 4,
    localparam int AW   = $clog2(NARCH),
    localparam int PW   = $clog2(NPHYS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [W-1:0]    in_slot,
    input  logic [W*3-1:0]  in_kind,
    input  logic [W*AW-1:0] in_src,
    input  logic [W*AW-1:0] in_dst,
    output logic            in_ready,
    input  logic [W-1:0]    rel_vld,
    input  logic [W*PW-1:0] rel_tag,
    output logic            out_vld,
    output logic [W-1:0]    out_slot,
    output logic [W*PW-1:0] out_ps,
    output logic [W*PW-1:0] out_pd,
    output logic [W*PW-1:0] out_old,
    output logic [W-1:0]    out_done,
    output logic [W-1:0]    out_exe
);
    localparam int NW = $clog2(W + 1);
    localparam int FW = $clog2(NPHYS + 1);

    logic [NARCH-1:0][PW-1:0] map_q, map_n;
    logic [NPHYS-1:0][CW-1:0] cnt;
    logic [NPHYS-1:0]         freed;
    logic [W-1:0][PW-1:0]     pick, ps, pd, old;
    logic [W-1:0]             done, exe, elim, alloc;
    logic [NW-1:0]            need;
    logic [FW-1:0]            avail;
    logic                     accept;
    rr_state_e                state_q, state_d;

    rr_group_decode #(.NARCH(NARCH), .NPHYS(NPHYS), .CW(CW), .W(W)) u_dec (
        .map_i(map_q), .cnt_i(cnt), .pick_i(pick), .slot_i(in_slot),
        .kind_i(in_kind), .src_i(in_src), .dst_i(in_dst), .map_o(map_n),
        .ps_o(ps), .pd_o(pd), .old_o(old), .done_o(done), .exe_o(exe),
        .elim_o(elim), .alloc_o(alloc), .need_o(need)
    );

    rr_free_pool #(.NARCH(NARCH), .NPHYS(NPHYS), .W(W)) u_pool (
        .clk(clk), .rst_n(rst_n), .take_v(alloc & {W{accept}}), .take_t(pd),
        .give_i(freed), .pick_o(pick), .avail_o(avail)
    );

    rr_ref_table #(.NARCH(NARCH), .NPHYS(NPHYS), .CW(CW), .W(W)) u_ref (
        .clk(clk), .rst_n(rst_n),
        .set_v(alloc & {W{accept}}), .set_t(pd),
        .inc_v(elim & {W{accept}}), .inc_t(ps),
        .dec_v(rel_vld), .dec_t(rel_tag),
        .cnt_o(cnt), .freed_o(freed)
    );

    assign in_ready = (FW'(need) <= avail);
    assign accept   = in_valid && in_ready;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_EMIT, ST_HOLD: begin
                if (accept)        state_d = ST_EMIT;
                else if (in_valid) state_d = ST_HOLD;
                else               state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb out_vld = (state_q == ST_EMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < NARCH; r++) map_q[r] <= PW'(r);
            out_slot <= '0;
            out_ps   <= '0;
            out_pd   <= '0;
            out_old  <= '0;
            out_done <= '0;
            out_exe  <= '0;
        end else if (accept) begin
            map_q    <= map_n;
            out_slot <= in_slot;
            out_ps   <= ps;
            out_pd   <= pd;
            out_old  <= old;
            out_done <= done;
            out_exe  <= exe;
        end
    end
endmodule

// File: rtl/rr_rename_chk.sv
`timescale 1ns/1ps
module rr_rename_chk #(
    parameter int W  = 4,
    parameter int AW = 4,
    parameter int PW = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            in_ready,
    input logic [W-1:0]    in_slot,
    input logic [W*3-1:0]  in_kind,
    input logic [W*AW-1:0] in_src,
    input logic [W*AW-1:0] in_dst,
    input logic            out_vld,
    input logic [W-1:0]    out_slot,
    input logic [W*PW-1:0] out_ps,
    input logic [W*PW-1:0] out_pd,
    input logic [W-1:0]    out_done,
    input logic [W-1:0]    out_exe
);
    assert_stall_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !in_ready |=> !out_vld);

    assert_emit_next_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_vld);

    for (genvar i = 0; i < W; i++) begin : g_slot
        assert_exec_fresh_R7: assert property (@(posedge clk) disable iff (!rst_n)
            out_vld && out_slot[i] && out_exe[i] |-> out_pd[i*PW +: PW] != out_ps[i*PW +: PW]);

        assert_self_move_R3: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && in_ready && in_slot[i] && in_kind[i*3 +: 3] == 3'd1 &&
            in_src[i*AW +: AW] == in_dst[i*AW +: AW] |=> out_exe[i] && !out_done[i]);

        assert_nop_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && in_ready && in_slot[i] && in_kind[i*3 +: 3] == 3'd2
            |=> out_done[i] && !out_exe[i]);

        assert_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
            out_vld && out_slot[i] |-> $onehot({out_done[i], out_exe[i]}));

        for (genvar j = i + 1; j < W; j++) begin : g_pair
            assert_distinct_alloc_R7: assert property (@(posedge clk) disable iff (!rst_n)
                out_vld && out_slot[i] && out_slot[j] && out_exe[i] && out_exe[j]
                |-> out_pd[i*PW +: PW] != out_pd[j*PW +: PW]);
        end
    end
endmodule

bind rr_rename_top rr_rename_chk #(.W(W), .AW(AW), .PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_slot(in_slot), .in_kind(in_kind), .in_src(in_src), .in_dst(in_dst),
    .out_vld(out_vld), .out_slot(out_slot), .out_ps(out_ps), .out_pd(out_pd),
    .out_done(out_done), .out_exe(out_exe)
);

// File: tb/sim_rr_rename_top.sv
`timescale 1ns/1ps
module sim_rr_rename_top;
    localparam int NARCH = 16, NPHYS = 48, W = 4, AW = 4, PW = 6, CMAX = 7, QN = 4096;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic            in_valid = 1'b0;
    logic [W-1:0]    in_slot = '0;
    logic [W*3-1:0]  in_kind = '0;
    logic [W*AW-1:0] in_src = '0, in_dst = '0;
    logic            in_ready;
    logic [W-1:0]    rel_vld = '0;
    logic [W*PW-1:0] rel_tag = '0;
    logic            out_vld;
    logic [W-1:0]    out_slot, out_done, out_exe;
    logic [W*PW-1:0] out_ps, out_pd, out_old;

    rr_rename_top u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_slot(in_slot),
        .in_kind(in_kind), .in_src(in_src), .in_dst(in_dst), .in_ready(in_ready),
        .rel_vld(rel_vld), .rel_tag(rel_tag), .out_vld(out_vld), .out_slot(out_slot),
        .out_ps(out_ps), .out_pd(out_pd), .out_old(out_old), .out_done(out_done),
        .out_exe(out_exe)
    );

    int total = 0, bad = 0;
    int amap[NARCH];
    int refs[NPHYS];
    int pq[QN];
    int ph = 0, pt = 0;
    int d_slot[W], d_kind[W], d_src[W], d_dst[W];
    int stalls = 0, fallbacks = 0;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic set_op(input int i, input int k, input int s, input int d);
        d_slot[i] = 1; d_kind[i] = k; d_src[i] = s; d_dst[i] = d;
    endtask

    task automatic clear_ops();
        for (int i = 0; i < W; i++) begin
            d_slot[i] = 0; d_kind[i] = 2; d_src[i] = 0; d_dst[i] = 0;
        end
    endtask

    task automatic check_group();
        for (int i = 0; i < W; i++) begin
            int k, ps, pd, od, eps;
            bit mv, el;
            string tg;
            if (d_slot[i] == 0) continue;
            k  = d_kind[i];
            ps = int'(out_ps[i*PW +: PW]);
            pd = int'(out_pd[i*PW +: PW]);
            od = int'(out_old[i*PW +: PW]);
            eps = amap[d_src[i]];
            chk(ps == eps, "R6 source tag", ps, eps);
            if (k == 2) begin
                chk(out_done[i] && !out_exe[i], "R4 nop flags", {out_done[i], out_exe[i]}, 2);
                continue;
            end
            chk(od == amap[d_dst[i]], "R10 old tag", od, amap[d_dst[i]]);
            mv = (k == 1 || k == 4) && d_src[i] != d_dst[i];
            el = mv && refs[eps] < CMAX;
            if (el) begin
                tg = (k == 4) ? "R5 zx8 elim" : "R2 move elim";
                chk(pd == eps, tg, pd, eps);
                chk(out_done[i] && !out_exe[i], tg, {out_done[i], out_exe[i]}, 2);
                refs[eps]++;
            end else begin
                if (mv) begin tg = "R8 fallback"; fallbacks++; end
                else if (k == 1) tg = "R3 self move";
                else if (k == 5) tg = "R5 zx16";
                else if (k == 3) tg = "R4 zero idiom";
                else tg = "R7 alu";
                chk(refs[pd] == 0, "R7 fresh tag unreferenced", refs[pd], 0);
                chk(out_exe[i] == (k != 3), tg, out_exe[i], k != 3);
                chk(out_done[i] == (k == 3), tg, out_done[i], k == 3);
                refs[pd] = 1;
            end
            pq[pt % QN] = od;
            pt++;
            amap[d_dst[i]] = pd;
        end
    endtask

    task automatic step(input bit valid, input int nrel, output bit acc);
        int pm[NARCH];
        int pr[NPHYS];
        int need, freec, nr;
        bit er;
        nr = (nrel < pt - ph) ? nrel : pt - ph;
        for (int i = 0; i < W; i++) begin
            rel_vld[i] = (i < nr);
            rel_tag[i*PW +: PW] = (i < nr) ? PW'(pq[(ph + i) % QN]) : '0;
            in_slot[i] = d_slot[i][0];
            in_kind[i*3 +: 3] = 3'(d_kind[i]);
            in_src[i*AW +: AW] = AW'(d_src[i]);
            in_dst[i*AW +: AW] = AW'(d_dst[i]);
        end
        in_valid = valid;
        pm = amap; pr = refs; need = 0;
        for (int i = 0; i < W; i++) begin
            int s, k;
            if (d_slot[i] == 0 || d_kind[i] == 2) continue;
            k = d_kind[i];
            s = pm[d_src[i]];
            if ((k == 1 || k == 4) && d_src[i] != d_dst[i] && (s < 0 || pr[s] < CMAX)) begin
                if (s >= 0) pr[s]++;
                pm[d_dst[i]] = s;
            end else begin
                need++;
                pm[d_dst[i]] = -1;
            end
        end
        freec = 0;
        for (int p = 0; p < NPHYS; p++) if (refs[p] == 0) freec++;
        er = (need <= freec);
        #1;
        chk(in_ready === er, "R9 ready", in_ready, er);
        acc = valid && er;
        if (valid && !er) stalls++;
        @(posedge clk);
        @(negedge clk);
        if (acc) begin
            chk(out_vld === 1'b1, "R11 out valid", out_vld, 1);
            check_group();
        end else begin
            chk(out_vld === 1'b0, "R9 no output", out_vld, 0);
        end
        for (int i = 0; i < nr; i++) refs[pq[(ph + i) % QN]]--;
        ph += nr;
        rel_vld = '0;
        in_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        total++; bad++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit acc;
        void'($urandom(32'd20240611));
        for (int r = 0; r < NARCH; r++) amap[r] = r;
        for (int p = 0; p < NPHYS; p++) refs[p] = (p < NARCH) ? 1 : 0;
        clear_ops();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(out_vld === 1'b0, "R1 reset out_vld", out_vld, 0);
        chk(in_ready === 1'b1, "R1 reset ready", in_ready, 1);

        // R1: lowest-first allocation after reset
        clear_ops();
        for (int i = 0; i < W; i++) set_op(i, 0, i, i + 1);
        step(1, 0, acc);
        for (int i = 0; i < W; i++)
            chk(int'(out_pd[i*PW +: PW]) == 16 + i, "R1 first tags", int'(out_pd[i*PW +: PW]), 16 + i);

        // R6: dependent chain inside one group
        clear_ops();
        set_op(0, 1, 1, 5); set_op(1, 0, 5, 6); set_op(2, 1, 6, 7); set_op(3, 3, 0, 8);
        step(1, 2, acc);

        // R3 R5 R4
        clear_ops();
        set_op(0, 1, 2, 2); set_op(1, 4, 3, 9); set_op(2, 5, 3, 10); set_op(3, 2, 11, 11);
        step(1, 2, acc);

        // R8: saturate the count of r0's register
        clear_ops();
        for (int i = 0; i < W; i++) set_op(i, 1, 0, i + 1);
        step(1, 0, acc);
        clear_ops();
        for (int i = 0; i < W; i++) set_op(i, (i == 3) ? 4 : 1, 0, i + 5);
        step(1, 0, acc);
        chk(fallbacks >= 2, "R8 saturation fallback", fallbacks, 2);

        // R9: exhaust the free pool without releases
        for (int g = 0; g < 12; g++) begin
            clear_ops();
            for (int i = 0; i < W; i++) set_op(i, 0, 12, 12 + i);
            step(1, 0, acc);
        end
        chk(stalls > 0, "R9 stall seen", stalls, 1);
        // R10: releases restore capacity
        repeat (40) begin clear_ops(); step(0, 4, acc); end

        // random mix
        for (int n = 0; n < 3000; n++) begin
            clear_ops();
            for (int i = 0; i < W; i++) begin
                int r, k, s;
                r = $urandom % 10;
                k = (r < 3) ? 0 : (r < 6) ? 1 : (r == 6) ? 2 : (r == 7) ? 3 : (r == 8) ? 4 : 5;
                s = ($urandom % 2) ? $urandom % 4 : $urandom % 16;
                if ($urandom % 100 < 85) set_op(i, k, s, $urandom % 16);
            end
            step(($urandom % 10) < 8, $urandom % 5, acc);
        end
        repeat (400) begin clear_ops(); step(0, 4, acc); end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule